// File: doc/BRIEF.md
# Input Pin Capture Cell

This block sits between a bank of dedicated input pins and a programmable logic array. For each pin it hands the array a value in both true and inverted form. That value comes from one of three sources, chosen by a static mode field:

- the pin itself, passed straight through;
- a flip-flop that captures the pin on a rising edge of an effective clock;
- a level-sensitive latch that is open while the effective clock is high.

All pins in the bank share one effective clock. It is built from one of three sources: two dedicated clock pins, or a clock formed from array product terms. A polarity bit can invert the chosen source.

The block runs in a single system clock domain. The three clock sources are treated as sampled data. An edge of the effective clock is recognised when the system clock samples it high after having sampled it low. The latch stays transparent at the output for as long as the effective clock is high. While it is open, its stored copy is refreshed on every system clock edge.

Top module: `incap_cell`

## Requirements
- R1: With `cap_mode` = 2'b00 (pass), `arr_true` equals `pin` in the same cycle, with no storage involved.
- R2: With `cap_mode` = 2'b01 (edge), the stored value takes `pin` at a system clock edge where the effective clock is sampled high and was sampled low at the previous edge. It holds at every other edge. `arr_true` shows the stored value.
- R3: With `cap_mode` = 2'b10 (level), while the effective clock is high `arr_true` follows `pin` combinationally, and the stored copy loads `pin` at every system clock edge.
- R4: With `cap_mode` = 2'b10, while the effective clock is low `arr_true` holds the `pin` value from the last system clock edge at which the effective clock was high.
- R5: `clk_src` picks the effective clock source as follows: 2'b00 selects `clk_pin1`, 2'b01 selects `clk_pin2`, 2'b10 selects `pterm_clk`, and 2'b11 selects `clk_pin1`. Activity on the sources that are not selected has no effect.
- R6: With `clk_inv` = 1 the selected source is inverted. Edge mode then captures on its falling edge, and level mode is transparent while it is low.
- R7: `arr_comp` is always the bitwise inverse of `arr_true`.
- R8: While `rst_n` is low at a system clock edge, the stored value clears to 0 and the recorded previous effective clock level clears to low.
- R9: `cap_mode` = 2'b11 behaves as pass (R1) and leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_mode | input | 2 | Capture mode (static configuration) |
| clk_src | input | 2 | Effective clock source select (static configuration) |
| clk_inv | input | 1 | Invert the selected clock source |
| clk_pin1 | input | 1 | Dedicated clock pin 1 |
| clk_pin2 | input | 1 | Dedicated clock pin 2 |
| pterm_clk | input | 1 | Product-term clock from the array |
| pin | input | WIDTH | Input pin values |
| arr_true | output | WIDTH | Value to the array, true form |
| arr_comp | output | WIDTH | Value to the array, complement form |

## Verification
Pass mode and latch transparency are combinational, so they are due in the same cycle as the stimulus. Stored values, whether from an edge capture or a latch refresh, become visible one system clock after the edge that samples them. The bench changes inputs just after the falling system clock edge and checks the outputs 1 ns later. At that point the combinational paths reflect the new inputs, and the stored state reflects the preceding rising edge. The reference model advances on each rising edge using the same inputs.

// File: rtl/incap_pkg.sv
// Shared encodings for the input capture cell.
package incap_pkg;
    typedef enum logic [1:0] {
        CAP_PASS  = 2'b00,
        CAP_EDGE  = 2'b01,
        CAP_LEVEL = 2'b10,
        CAP_ALT   = 2'b11
    } cap_mode_e;

    typedef enum logic [1:0] {
        SRC_PIN1  = 2'b00,
        SRC_PIN2  = 2'b01,
        SRC_PTERM = 2'b10,
        SRC_SPARE = 2'b11
    } clk_src_e;
endpackage

// File: rtl/incap_clk_sel.sv
// Effective clock builder: selects one of three clock sources and
// applies optional inversion. Purely combinational.
// Assumes src and inv are static configuration.
module incap_clk_sel
    import incap_pkg::*;
(
    input  logic     clk_pin1,
    input  logic     clk_pin2,
    input  logic     pterm_clk,
    input  clk_src_e src,
    input  logic     inv,
    output logic     eff_clk
);
    logic raw_clk;

    // Choose the raw source; the spare code falls back to pin 1.
    always_comb begin
        unique case (src)
            SRC_PIN1:  raw_clk = clk_pin1;
            SRC_PIN2:  raw_clk = clk_pin2;
            SRC_PTERM: raw_clk = pterm_clk;
            default:   raw_clk = clk_pin1;
        endcase
    end

    // Apply polarity control.
    always_comb eff_clk = raw_clk ^ inv;
endmodule

// File: rtl/incap_edge.sv
// Rising-edge detector for the sampled effective clock.
// Assumes the effective clock is slow relative to clk.
module incap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic eff_clk,
    output logic rise
);
    logic prev_lvl;

    // Remember the effective clock level at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= eff_clk;
    end

    // A rise is high now after low at the previous edge.
    always_comb rise = eff_clk & ~prev_lvl;

    a_r8_prev_cleared: assert property (@(posedge clk)
        !rst_n |=> !prev_lvl)
        else $error("a_r8_prev_cleared");
endmodule

// File: rtl/incap_store.sv
// Storage for the captured pin values: an edge register or a level
// latch modelled in the clk domain. Pass modes leave it unchanged.
// Assumes mode is static while the block runs.
module incap_store
    import incap_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_mode_e        mode,
    input  logic             eff_clk,
    input  logic             rise,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] store
);
    logic load;

    // Decide whether this edge loads the pin value.
    always_comb begin
        unique case (mode)
            CAP_EDGE:  load = rise;
            CAP_LEVEL: load = eff_clk;
            default:   load = 1'b0;
        endcase
    end

    // Hold or load the stored bank; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    store <= '0;
        else if (load) store <= pin;
    end

    a_r2_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_EDGE && rise) |=> store == $past(pin))
        else $error("a_r2_capture_on_rise");

    a_r2_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_EDGE && !rise) |=> $stable(store))
        else $error("a_r2_hold_without_rise");

    a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_LEVEL && eff_clk) |=> store == $past(pin))
        else $error("a_r3_level_tracks");

    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_LEVEL && !eff_clk) |=> $stable(store))
        else $error("a_r4_level_holds");

    a_r9_alt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_ALT) |=> $stable(store))
        else $error("a_r9_alt_holds");

    a_r8_store_cleared: assert property (@(posedge clk)
        !rst_n |=> store == '0)
        else $error("a_r8_store_cleared");
endmodule

// File: rtl/incap_out.sv
// Output selection per pin: pin or stored value, in true and
// complement form. Combinational; a bank of identical bit slices.
module incap_out
    import incap_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  cap_mode_e        mode,
    input  logic             eff_clk,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] store,
    output logic [WIDTH-1:0] arr_true,
    output logic [WIDTH-1:0] arr_comp
);
    logic use_pin;

    // Pin is visible in pass modes and while the level latch is open.
    always_comb begin
        unique case (mode)
            CAP_LEVEL: use_pin = eff_clk;
            CAP_EDGE:  use_pin = 1'b0;
            default:   use_pin = 1'b1;
        endcase
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Per-bit source mux with complement.
        always_comb begin
            arr_true[b] = use_pin ? pin[b] : store[b];
            arr_comp[b] = ~arr_true[b];
        end
    end
endmodule

// File: rtl/incap_cell.sv
// Input capture cell top: a bank of WIDTH pins sharing one effective
// clock built from three sources with polarity control.
// Assumes cap_mode, clk_src and clk_inv are static configuration.
module incap_cell
    import incap_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cap_mode,
    input  logic [1:0]       clk_src,
    input  logic             clk_inv,
    input  logic             clk_pin1,
    input  logic             clk_pin2,
    input  logic             pterm_clk,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] arr_true,
    output logic [WIDTH-1:0] arr_comp
);
    cap_mode_e        mode;
    clk_src_e         src;
    logic             eff_clk;
    logic             rise;
    logic [WIDTH-1:0] store;

    // Decode configuration fields into their enumerated forms.
    always_comb begin
        mode = cap_mode_e'(cap_mode);
        src  = clk_src_e'(clk_src);
    end

    incap_clk_sel u_clk_sel (
        .clk_pin1 (clk_pin1),
        .clk_pin2 (clk_pin2),
        .pterm_clk(pterm_clk),
        .src      (src),
        .inv      (clk_inv),
        .eff_clk  (eff_clk)
    );

    incap_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .eff_clk(eff_clk),
        .rise   (rise)
    );

    incap_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .eff_clk(eff_clk),
        .rise   (rise),
        .pin    (pin),
        .store  (store)
    );

    incap_out #(.WIDTH(WIDTH)) u_out (
        .mode    (mode),
        .eff_clk (eff_clk),
        .pin     (pin),
        .store   (store),
        .arr_true(arr_true),
        .arr_comp(arr_comp)
    );

    a_r1_pass_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == 2'b00) |-> arr_true == pin)
        else $error("a_r1_pass_follows_pin");
endmodule

// File: tb/incap_cell_tb_top.sv
module incap_cell_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cap_mode = 2'b01;
    logic [1:0]   clk_src = 2'b00;
    logic         clk_inv = 1'b0;
    logic         clk_pin1 = 1'b0;
    logic         clk_pin2 = 1'b0;
    logic         pterm_clk = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] arr_true;
    logic [W-1:0] arr_comp;

    int n_run  = 0;
    int n_fail = 0;

    logic [W-1:0] m_store = '0;
    logic         m_prev  = 1'b0;

    always #4 clk = ~clk;

    incap_cell #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .clk_src(clk_src),
        .clk_inv(clk_inv), .clk_pin1(clk_pin1), .clk_pin2(clk_pin2),
        .pterm_clk(pterm_clk), .pin(pin), .arr_true(arr_true), .arr_comp(arr_comp)
    );

    function automatic logic eff_of(logic [1:0] s, logic iv, logic a, logic b, logic p);
        logic r;
        case (s)
            2'b01:   r = b;
            2'b10:   r = p;
            default: r = a;
        endcase
        return r ^ iv;
    endfunction

    function automatic logic [W-1:0] exp_of(logic [1:0] m, logic e, logic [W-1:0] p,
                                            logic [W-1:0] st);
        if (m == 2'b01) return st;
        if (m == 2'b10) return e ? p : st;
        return p;
    endfunction

    // Reference model advances on each rising edge.
    always @(posedge clk) begin
        logic e;
        e = eff_of(clk_src, clk_inv, clk_pin1, clk_pin2, pterm_clk);
        if (!rst_n) begin
            m_store = '0;
            m_prev  = 1'b0;
        end else begin
            if (cap_mode == 2'b01 && e && !m_prev) m_store = pin;
            if (cap_mode == 2'b10 && e) m_store = pin;
            m_prev = e;
        end
    end

    task automatic chk(string tag);
        logic [W-1:0] ex;
        ex = exp_of(cap_mode, eff_of(clk_src, clk_inv, clk_pin1, clk_pin2, pterm_clk),
                    pin, m_store);
        n_run++;
        if (arr_true !== ex) begin
            n_fail++;
            $display("FAIL %s arr_true actual=%h expected=%h", tag, arr_true, ex);
        end
        n_run++;
        if (arr_comp !== ~ex) begin
            n_fail++;
            $display("FAIL R7 arr_comp actual=%h expected=%h", arr_comp, ~ex);
        end
    endtask

    task automatic drv(logic a, logic b, logic p, logic [W-1:0] d, string tag);
        @(negedge clk);
        clk_pin1 = a; clk_pin2 = b; pterm_clk = p; pin = d;
        #1 chk(tag);
    endtask

    function automatic string tag_of(logic [1:0] m, logic e);
        if (m == 2'b00) return "R1";
        if (m == 2'b11) return "R9";
        if (m == 2'b01) return "R2";
        return e ? "R3" : "R4";
    endfunction

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        pin = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R8");                       // cleared store visible in edge mode
        n_run++;
        if (arr_true !== 8'h00) begin
            n_fail++;
            $display("FAIL R8 reset value actual=%h expected=00", arr_true);
        end

        // R2: capture on pin1 rising, hold afterwards
        drv(0, 0, 0, 8'h3C, "R2");
        drv(1, 0, 0, 8'h3C, "R2");
        drv(1, 0, 0, 8'hFF, "R2");          // shows 3C captured at the rise
        n_run++;
        if (arr_true !== 8'h3C) begin
            n_fail++;
            $display("FAIL R2 captured actual=%h expected=3c", arr_true);
        end
        drv(0, 0, 0, 8'h11, "R2");

        // R5: select pin2; pin1 and pterm activity ignored
        clk_src = 2'b01;
        drv(1, 0, 1, 8'h77, "R5");
        drv(0, 0, 0, 8'h78, "R5");
        drv(1, 0, 1, 8'h79, "R5");
        drv(1, 0, 1, 8'h7A, "R5");          // store must still be 3C
        drv(0, 1, 0, 8'h5A, "R5");
        drv(0, 1, 0, 8'h00, "R5");          // now 5A
        clk_src = 2'b10;
        drv(0, 0, 0, 8'h00, "R5");
        drv(0, 0, 1, 8'hC3, "R5");
        drv(0, 0, 1, 8'h01, "R5");          // pterm captured C3
        clk_src = 2'b11;
        drv(0, 0, 0, 8'h01, "R5");
        drv(1, 0, 0, 8'h96, "R5");
        drv(1, 0, 0, 8'h02, "R5");          // spare code uses pin1

        // R6: inverted pin1, capture on its falling edge
        clk_src = 2'b00; clk_inv = 1'b1;
        drv(1, 0, 0, 8'h02, "R6");
        drv(1, 0, 0, 8'h02, "R6");
        drv(0, 0, 0, 8'hE7, "R6");
        drv(0, 0, 0, 8'h03, "R6");          // E7 captured
        cap_mode = 2'b10;
        drv(0, 0, 0, 8'h44, "R6");          // inverted level: transparent when pin1 low
        drv(1, 0, 0, 8'h45, "R6");          // closed, holds 44
        clk_inv = 1'b0;

        // R3/R4: latch open and closed
        drv(1, 0, 0, 8'h12, "R3");
        drv(1, 0, 0, 8'h34, "R3");
        drv(0, 0, 0, 8'h56, "R4");          // holds 34
        drv(0, 0, 0, 8'h9A, "R4");

        // R9: alternate code passes pin, store untouched
        cap_mode = 2'b11;
        drv(1, 0, 0, 8'hBE, "R9");
        drv(0, 0, 0, 8'hEF, "R9");
        cap_mode = 2'b01;
        drv(0, 0, 0, 8'h00, "R9");          // store still 34

        // R1: pass mode
        cap_mode = 2'b00;
        drv(0, 0, 0, 8'h81, "R1");
        drv(1, 1, 1, 8'h7E, "R1");

        // Random phase
        for (int seg = 0; seg < 40; seg++) begin
            cap_mode = 2'($urandom_range(0, 3));
            clk_src  = 2'($urandom_range(0, 3));
            clk_inv  = 1'($urandom_range(0, 1));
            for (int k = 0; k < 50; k++) begin
                logic a, b, p;
                a = ($urandom_range(0, 3) == 0) ? ~clk_pin1 : clk_pin1;
                b = ($urandom_range(0, 3) == 0) ? ~clk_pin2 : clk_pin2;
                p = ($urandom_range(0, 3) == 0) ? ~pterm_clk : pterm_clk;
                drv(a, b, p, W'($urandom),
                    tag_of(cap_mode, eff_of(clk_src, clk_inv, a, b, p)));
            end
        end

        // R8: reset mid-run in edge mode clears store
        cap_mode = 2'b01;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        #1 chk("R8");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule